// File: doc/BRIEF.md
# Accelerator Command and Status Controller

This block is the register front end of a compute accelerator. A host reaches it over a simple 32-bit memory-mapped bus. The bus sees a control word, a status word, a flag-clear word and a window onto an operand RAM. The controller does the following:

- checks every opcode the host writes against a parameterised list of supported operations, and a stricter list when the chip is in restricted mode;
- launches jobs;
- keeps a busy indication for as long as a job runs;
- latches completion and error events as sticky flags;
- drives one interrupt line built from those flags and per-flag enables.

The arithmetic engine is not part of this block. A stub engine with a fixed, parameterised latency stands in for it. A launch with an opcode that is not allowed still occupies the engine for a short fixed abort window, and then releases it without reporting completion. The operand RAM is a plain inferred word array. The host may use it only while no job is running. Readiness of the random source used at initialisation arrives as an input and is reflected in the status word.

Top module: `accel_ctrl_front`

## Requirements
- R1: After reset the control word and the status word read 0 (with the random-ready input low), and `irq` is 0.
- R2: A control write stores enable (bit 0), a 6-bit opcode (bits 13:8) and the interrupt enables at bits 17 (completion), 19 (RAM conflict), 20 (address fault) and 21 (opcode fault); reading it back returns these fields, and bit 1 (start) always reads 0.
- R3: A control write with bit 0 set whose opcode is not marked in the `OPCODE_MASK` parameter keeps the previous opcode and sets the opcode-fault flag (status bit 21); a control write with bit 0 clear stores any opcode.
- R4: While `limited_mode` is 1, a control write with bit 0 set and an opcode other than 0x26 is rejected as in R3.
- R5: A control write with bits 0 and 1 set while idle launches the stored opcode: busy (status bit 16) is 1 for exactly `JOB_CYCLES` cycles starting the cycle after the write, and the completion flag (status bit 17) sets on the edge where busy falls.
- R6: A start write while busy is ignored and does not extend the running job.
- R7: A launch whose stored opcode is not allowed sets the opcode-fault flag, keeps busy for exactly 4 cycles and sets no completion flag.
- R8: While idle, RAM word n at byte address 0x400 + 4n can be written, and it is read back one cycle after the read request.
- R9: A RAM-window access inside the array while busy returns 0, drops the write and sets the RAM-conflict flag (status bit 19).
- R10: An access to a RAM-window word at or above `RAM_WORDS`, or to any offset from 0x0C up to 0x3FC, returns 0 and sets the address-fault flag (status bit 20).
- R11: Writing 1 to a flag's bit position at offset 0x08 clears that flag, but a flag whose set event falls in the same cycle stays set.
- R12: `irq` is 1 exactly when some status flag is set together with its control enable bit.
- R13: Status bit 0 follows `rng_ready` with one cycle of delay and stays 0 while `rng_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rng_ready | input | 1 | Random source able to deliver values |
| limited_mode | input | 1 | Restricts the allowed opcodes to 0x26 |
| bus_req | input | 1 | Bus access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with `RAM_WORDS` = 16 and `JOB_CYCLES` = 6, and keeps the default opcode set {0x00, 0x01, 0x02, 0x26}. The small array puts the first out-of-range word at 0x440, so an address fault above the array is easy to reach. The short job makes it possible to count busy one cycle at a time. It also lets a clear write land on the exact completion edge, and lets a second start land inside a running job. Because the abort window (4) differs from the job length (6), the bench can tell an aborted launch from a real one by its busy duration.

// File: rtl/accel_pkg.sv
package accel_pkg;
  // byte offsets of the register words and the RAM window
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_CLR  = 'h08;
  localparam int RAM_BASE = 'h400;

  // control and status bit positions
  localparam int BIT_EN   = 0;
  localparam int BIT_GO   = 1;
  localparam int OP_LSB   = 8;
  localparam int OP_W     = 6;
  localparam int BIT_INIT = 0;
  localparam int BIT_BUSY = 16;

  // sticky flags: index order shared by flag bank, enables and clears
  localparam int NFLAG = 4;
  localparam int FL_EOP = 0;
  localparam int FL_RAM = 1;
  localparam int FL_ADR = 2;
  localparam int FL_OPC = 3;
  localparam int FLAG_POS [NFLAG] = '{17, 19, 20, 21};

  localparam logic [OP_W-1:0] LIMITED_OP = 6'h26;
  localparam int ABORT_CYCLES = 4;

  typedef enum logic [1:0] {RS_ZERO, RS_REG, RS_RAM} rsel_e;

  function automatic logic op_allowed(input logic [63:0] mask,
                                      input logic [OP_W-1:0] op,
                                      input logic lim);
    return mask[op] && (!lim || op == LIMITED_OP);
  endfunction
endpackage

// File: rtl/accel_stub_engine.sv
module accel_stub_engine #(
  parameter int JOB_CYCLES   = 16,
  parameter int ABORT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic bad_op,
  output logic busy,
  output logic done,
  output logic done_ok
);
  localparam int MAXLAT = (JOB_CYCLES > ABORT_CYCLES) ? JOB_CYCLES : ABORT_CYCLES;
  localparam int CNT_W  = $clog2(MAXLAT + 1);

  logic             run_q, run_n;
  logic             bad_q, bad_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  assign busy    = run_q;
  assign done    = run_q && (cnt_q == '0);
  assign done_ok = done && !bad_q;

  always_comb begin
    run_n = run_q;
    bad_n = bad_q;
    cnt_n = cnt_q;
    if (launch) begin
      run_n = 1'b1;
      bad_n = bad_op;
      cnt_n = bad_op ? CNT_W'(ABORT_CYCLES - 1) : CNT_W'(JOB_CYCLES - 1);
    end else if (done) begin
      run_n = 1'b0;
    end else if (run_q) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      bad_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_n;
      bad_q <= bad_n;
      cnt_q <= cnt_n;
    end
  end

  // independent age counter for the length checks
  logic [CNT_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      age_q <= '0;
    else if (launch) age_q <= '0;
    else if (run_q)  age_q <= age_q + 1'b1;
  end

  // R5
  job_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |-> age_q == CNT_W'(JOB_CYCLES - 1));
  // R7
  abort_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bad_q) |-> age_q == CNT_W'(ABORT_CYCLES - 1));
endmodule

// File: rtl/accel_flag_bank.sv
module accel_flag_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ie_i,
  output logic [N-1:0] flag_o,
  output logic         irq
);
  logic [N-1:0] flag_q;

  generate
    for (genvar g = 0; g < N; g++) begin : g_flag
      logic nxt;
      // a set event in the clear cycle wins
      assign nxt = set_i[g] | (flag_q[g] & ~clr_i[g]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[g] <= 1'b0;
        else        flag_q[g] <= nxt;
      end

      // R11
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[g] |=> flag_q[g]);
      // R11
      clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[g] && !set_i[g]) |=> !flag_q[g]);
    end
  endgenerate

  assign flag_o = flag_q;
  assign irq    = |(flag_q & ie_i);
endmodule

// File: rtl/accel_operand_ram.sv
module accel_operand_ram #(
  parameter int WORDS = 1334,
  parameter int DW    = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (acc && we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rd_q <= '0;
    else if (acc && !we) rd_q <= mem[idx];
  end

  assign rdata = rd_q;
endmodule

// File: rtl/accel_ctrl_front.sv
module accel_ctrl_front
  import accel_pkg::*;
#(
  parameter int          ADDR_W      = 13,
  parameter int          RAM_WORDS   = 1334,
  parameter int          JOB_CYCLES  = 16,
  parameter logic [63:0] OPCODE_MASK = 64'h0000_0040_0000_0007
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rng_ready,
  input  logic              limited_mode,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int IDX_W = $clog2(RAM_WORDS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  // state
  logic             en_q, en_n;
  logic [OP_W-1:0]  op_q, op_n;
  logic [NFLAG-1:0] ie_q, ie_n;
  logic             init_q;
  rsel_e            rsel_q, rsel_n;
  logic [31:0]      rreg_q, rreg_n;

  // decode and control
  logic [WA_W-1:0]  wa, off;
  logic             in_win, ram_hit;
  logic             acc_ctrl, acc_stat, acc_clr, acc_hole, acc_far;
  logic             ram_go, ram_blk, wr_ctrl, op_reject, launch, launch_bad;
  logic [NFLAG-1:0] fset, fclr, flags;
  logic [31:0]      ctrl_w, stat_w, ram_rd;
  logic             eng_busy, eng_done, eng_ok;

  always_comb begin
    wa       = bus_addr[ADDR_W-1:2];
    in_win   = bus_addr >= ADDR_W'(RAM_BASE);
    off      = wa - WA_W'(RAM_BASE / 4);
    ram_hit  = in_win && (off < WA_W'(RAM_WORDS));
    acc_ctrl = bus_req && !in_win && (wa == WA_W'(OFS_CTRL / 4));
    acc_stat = bus_req && !in_win && (wa == WA_W'(OFS_STAT / 4));
    acc_clr  = bus_req && !in_win && (wa == WA_W'(OFS_CLR / 4));
    acc_hole = bus_req && !in_win && (wa > WA_W'(OFS_CLR / 4));
    acc_far  = bus_req && in_win && !ram_hit;
    ram_go   = bus_req && ram_hit && !eng_busy;
    ram_blk  = bus_req && ram_hit && eng_busy;

    wr_ctrl    = acc_ctrl && bus_we;
    op_reject  = wr_ctrl && bus_wdata[BIT_EN] &&
                 !op_allowed(OPCODE_MASK, bus_wdata[OP_LSB +: OP_W], limited_mode);
    op_n       = (wr_ctrl && !op_reject) ? bus_wdata[OP_LSB +: OP_W] : op_q;
    en_n       = wr_ctrl ? bus_wdata[BIT_EN] : en_q;
    launch     = wr_ctrl && bus_wdata[BIT_EN] && bus_wdata[BIT_GO] && !eng_busy;
    launch_bad = !op_allowed(OPCODE_MASK, op_n, limited_mode);

    for (int i = 0; i < NFLAG; i++) begin
      ie_n[i] = wr_ctrl ? bus_wdata[FLAG_POS[i]] : ie_q[i];
      fclr[i] = acc_clr && bus_we && bus_wdata[FLAG_POS[i]];
    end
    fset[FL_EOP] = eng_ok;
    fset[FL_RAM] = ram_blk;
    fset[FL_ADR] = acc_hole || acc_far;
    fset[FL_OPC] = op_reject || (launch && launch_bad);

    ctrl_w = '0;
    ctrl_w[BIT_EN] = en_q;
    ctrl_w[OP_LSB +: OP_W] = op_q;
    stat_w = '0;
    stat_w[BIT_INIT] = init_q;
    stat_w[BIT_BUSY] = eng_busy;
    for (int i = 0; i < NFLAG; i++) begin
      ctrl_w[FLAG_POS[i]] = ie_q[i];
      stat_w[FLAG_POS[i]] = flags[i];
    end

    rsel_n = RS_ZERO;
    rreg_n = rreg_q;
    if (bus_req && !bus_we) begin
      if (ram_go) begin
        rsel_n = RS_RAM;
      end else if (acc_ctrl) begin
        rsel_n = RS_REG;
        rreg_n = ctrl_w;
      end else if (acc_stat) begin
        rsel_n = RS_REG;
        rreg_n = stat_w;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q   <= 1'b0;
      op_q   <= '0;
      ie_q   <= '0;
      init_q <= 1'b0;
      rsel_q <= RS_ZERO;
      rreg_q <= '0;
    end else begin
      en_q   <= en_n;
      op_q   <= op_n;
      ie_q   <= ie_n;
      init_q <= rng_ready;
      rsel_q <= rsel_n;
      rreg_q <= rreg_n;
    end
  end

  always_comb begin
    unique case (rsel_q)
      RS_RAM:  bus_rdata = ram_rd;
      RS_REG:  bus_rdata = rreg_q;
      default: bus_rdata = '0;
    endcase
  end

  accel_stub_engine #(.JOB_CYCLES(JOB_CYCLES), .ABORT_CYCLES(ABORT_CYCLES)) u_engine (
    .clk(clk), .rst_n(rst_i_n), .launch(launch), .bad_op(launch_bad),
    .busy(eng_busy), .done(eng_done), .done_ok(eng_ok));

  accel_flag_bank #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_i_n), .set_i(fset), .clr_i(fclr), .ie_i(ie_q),
    .flag_o(flags), .irq(irq));

  accel_operand_ram #(.WORDS(RAM_WORDS), .DW(32)) u_ram (
    .clk(clk), .rst_n(rst_i_n), .acc(ram_go), .we(bus_we),
    .idx(off[IDX_W-1:0]), .wdata(bus_wdata), .rdata(ram_rd));

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:22], bus_wdata[18],
                         bus_wdata[16:14], bus_wdata[7:2], eng_done, en_q};

  // R12
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ie_q == '0) |-> !irq);
  // R5
  eop_fall_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(flags[FL_EOP]) |-> $fell(eng_busy));
  // R9
  blocked_read_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (ram_blk && !bus_we) |=> bus_rdata == '0);
  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    op_reject |=> $stable(op_q));
  // R13
  init_low_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rng_ready |=> !init_q);
endmodule

// File: tb/test_accel_ctrl_front.sv
`timescale 1ns/1ps
module test_accel_ctrl_front;
  localparam int AW = 13;
  localparam logic [AW-1:0] A_CTRL = 13'h000, A_STAT = 13'h004, A_CLR = 13'h008;
  localparam int S_BUSY = 16, S_EOP = 17, S_RAM = 19, S_ADR = 20, S_OPC = 21;

  // {limited, enable, opcode[5:0], expected opcode[5:0], expected opcode fault}
  localparam int NV = 8;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b1, 6'h01, 6'h01, 1'b0},
    {1'b0, 1'b1, 6'h05, 6'h01, 1'b1},
    {1'b0, 1'b1, 6'h26, 6'h26, 1'b0},
    {1'b0, 1'b0, 6'h3F, 6'h3F, 1'b0},
    {1'b0, 1'b1, 6'h02, 6'h02, 1'b0},
    {1'b1, 1'b1, 6'h01, 6'h02, 1'b1},
    {1'b1, 1'b1, 6'h26, 6'h26, 1'b0},
    {1'b1, 1'b0, 6'h00, 6'h00, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, rng_ready = 1'b0, limited_mode = 1'b0;
  logic bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  accel_ctrl_front #(.ADDR_W(AW), .RAM_WORDS(16), .JOB_CYCLES(6)) i_accel_ctrl_front (
    .clk(clk), .rst_n(rst_n), .rng_ready(rng_ready), .limited_mode(limited_mode),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    rd(A_STAT, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R13 init indication
    rng_ready = 1'b1;
    @(negedge clk);
    rd(A_STAT, d); chk("R13 init", {31'h0, d[0]}, 32'h1);

    // R2 control fields read back
    wr(A_CTRL, 32'h003A_0101);
    rd(A_CTRL, d); chk("R2 readback", d, 32'h003A_0101);
    wr(A_CTRL, 32'h0000_0000);

    // R3 / R4 opcode acceptance table
    for (int i = 0; i < NV; i++) begin
      limited_mode = VEC[i][14];
      wr(A_CTRL, {18'h0, VEC[i][12:7], 7'h0, VEC[i][13]});
      rd(A_CTRL, d);
      chk(VEC[i][14] ? "R4 opcode" : "R3 opcode", {26'h0, d[13:8]}, {26'h0, VEC[i][6:1]});
      rd(A_STAT, d);
      chk(VEC[i][14] ? "R4 fault" : "R3 fault", {31'h0, d[S_OPC]}, {31'h0, VEC[i][0]});
      wr(A_CLR, 32'h1 << S_OPC);
    end
    limited_mode = 1'b0;

    // R5 busy length and completion, R12 interrupt
    wr(A_CTRL, 32'h0002_0103);
    for (int i = 0; i < 7; i++) begin
      rd(A_STAT, d);
      chk("R5 busy", {31'h0, d[S_BUSY]}, {31'h0, (i < 6)});
    end
    chk("R5 completion", {31'h0, d[S_EOP]}, 32'h1);
    chk("R12 irq set", {31'h0, irq}, 32'h1);
    rd(A_CTRL, d); chk("R2 start reads 0", d, 32'h0002_0101);
    wr(A_CLR, 32'h1 << S_EOP);
    chk("R12 irq cleared", {31'h0, irq}, 32'h0);

    // R11 clear on the completion edge loses
    wr(A_CTRL, 32'h0000_0103);
    for (int i = 0; i < 5; i++) rd(A_STAT, d);
    wr(A_CLR, 32'h1 << S_EOP);
    rd(A_STAT, d);
    chk("R11 set wins", {30'h0, d[S_EOP], d[S_BUSY]}, 32'h2);
    wr(A_CLR, 32'h1 << S_EOP);
    rd(A_STAT, d); chk("R11 cleared", {31'h0, d[S_EOP]}, 32'h0);

    // R6 second start while busy
    wr(A_CTRL, 32'h0000_0103);
    wr(A_CTRL, 32'h0000_0103);
    for (int i = 0; i < 6; i++) begin
      rd(A_STAT, d);
      chk("R6 busy", {31'h0, d[S_BUSY]}, {31'h0, (i < 5)});
    end
    wr(A_CLR, 32'h1 << S_EOP);

    // R7 launch with a stored opcode that is not allowed
    wr(A_CTRL, 32'h0000_3F00);
    wr(A_CTRL, 32'h0000_3F03);
    for (int i = 0; i < 5; i++) begin
      rd(A_STAT, d);
      chk("R7 busy", {31'h0, d[S_BUSY]}, {31'h0, (i < 4)});
    end
    chk("R7 no completion", {31'h0, d[S_EOP]}, 32'h0);
    chk("R7 fault", {31'h0, d[S_OPC]}, 32'h1);
    wr(A_CLR, 32'h1 << S_OPC);

    // R8 RAM access while idle
    wr(A_CTRL, 32'h0000_0000);
    wr(13'h40C, 32'hA5A5_0003);
    wr(13'h43C, 32'h5A5A_000F);
    rd(13'h40C, d); chk("R8 word3", d, 32'hA5A5_0003);
    rd(13'h43C, d); chk("R8 word15", d, 32'h5A5A_000F);
    rd(A_STAT, d); chk("R8 no error", {30'h0, d[S_ADR], d[S_RAM]}, 32'h0);

    // R9 RAM access while busy
    wr(A_CTRL, 32'h0000_0103);
    rd(13'h40C, d); chk("R9 read blocked", d, 32'h0);
    wr(13'h40C, 32'hDEAD_BEEF);
    repeat (8) @(negedge clk);
    rd(A_STAT, d); chk("R9 conflict flag", {31'h0, d[S_RAM]}, 32'h1);
    rd(13'h40C, d); chk("R9 write dropped", d, 32'hA5A5_0003);
    wr(A_CLR, (32'h1 << S_RAM) | (32'h1 << S_EOP));

    // R10 address faults
    wr(A_CTRL, 32'h0000_0000);
    rd(13'h440, d); chk("R10 past array", d, 32'h0);
    rd(A_STAT, d); chk("R10 flag far", {31'h0, d[S_ADR]}, 32'h1);
    chk("R12 masked", {31'h0, irq}, 32'h0);
    wr(A_CLR, 32'h1 << S_ADR);
    rd(13'h00C, d); chk("R10 hole", d, 32'h0);
    rd(A_STAT, d); chk("R10 flag hole", {31'h0, d[S_ADR]}, 32'h1);

    // R12 enable an existing flag
    wr(A_CTRL, 32'h1 << S_ADR);
    chk("R12 enabled", {31'h0, irq}, 32'h1);
    wr(A_CLR, 32'h1 << S_ADR);
    chk("R12 off", {31'h0, irq}, 32'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule